// File: doc/BRIEF.md
# Removable Media Presence Tracker

This block turns a removable-media detect pin into the sense status that a host-side storage command responder returns. The raw pin is synchronised and filtered before it is trusted, and its active level comes from a configuration bit. A second configuration bit turns detection off, and the medium is then always treated as present. The command layer pulses a query strobe whenever it needs status. One cycle later the block answers with a sense key and with additional sense code and qualifier bytes.

When the medium is taken out, every query reports that no medium is present. When a medium comes back, exactly one query reports that the medium has changed. After that, queries report good status again. If the medium is removed before the change has been reported, the absent report wins and the pending change is dropped. A medium that is already in place when reset ends does not count as a change.

The block also drives two fixed outputs for the storage bus side. The first is the bus address of the removable unit, which is always device 0. The second is a startup scan enable that follows a configuration bit.

Top module: `media_sense_tracker`

## Requirements
- R1: While reset is high and in the first cycle after it, media_present is 1 and rsp_valid is 0.
- R2: When cfg_detect_en is 0, media_present is 1 one cycle later, whatever det_raw does. Queries in that state return good status: key 0x0, code 0x00, qualifier 0x00.
- R3: When cfg_active_high is 1, a high det_raw means a medium is inserted. When it is 0, a low det_raw means a medium is inserted.
- R4: While the filtered detect says no medium is present, media_present is 0. Every query then returns key 0x2, code 0x3A, qualifier 0x00.
- R5: The first query after the filtered detect goes from absent back to present returns key 0x6, code 0x28, qualifier 0x00.
- R6: The change report is given to one query only. The next query, even in the following cycle, returns key 0x0, code 0x00, qualifier 0x00.
- R7: A removal that happens while a change report is still pending cancels it. Queries then return the absent status of R4.
- R8: det_raw passes through two flip-flops. A new level must then hold for DEBOUNCE_CYCLES consecutive cycles before it is accepted. A pulse shorter than that leaves media_present unchanged.
- R9: A medium that is present when reset is released does not produce a change report. The first query returns good status.
- R10: Each query cycle produces exactly one rsp_valid cycle, in the following cycle. rsp_valid is never high at any other time.
- R11: rem_unit_addr is always 0. scan_at_start equals cfg_bus_search one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| det_raw | input | 1 | Asynchronous removable-media detect pin |
| cfg_detect_en | input | 1 | 1 = use the detect pin; 0 = medium always present |
| cfg_active_high | input | 1 | 1 = pin high means inserted; 0 = pin low means inserted |
| cfg_bus_search | input | 1 | Enables the device scan of the storage bus at startup |
| query | input | 1 | One-cycle status request from the command layer |
| media_present | output | 1 | Filtered medium presence |
| rsp_valid | output | 1 | Response strobe, one cycle after each query |
| rsp_key | output | 4 | Sense key of the response |
| rsp_asc | output | 8 | Additional sense code of the response |
| rsp_ascq | output | 8 | Additional sense code qualifier of the response |
| rem_unit_addr | output | 1 | Storage bus address of the removable unit (always 0) |
| scan_at_start | output | 1 | Registered startup bus-scan enable |

## Verification
The assertions check, on every cycle, that a query is answered in the next cycle and that no strobe appears without one. They also check that an absent medium gives the no-medium code and never leaves a change pending. Further checks cover the forced presence when detection is off, and that the filtered level only moves when the hold counter expires. Only the bench's scenarios can show the rest. These are that a short glitch is ignored, that a reinsertion yields exactly one change report followed by good status, that a removal cancels a pending report, that the polarity bit swaps the meaning of the pin, and that a medium present at startup raises nothing.

// File: rtl/media_sense_pkg.sv
package media_sense_pkg;

  typedef struct packed {
    logic [3:0] key;
    logic [7:0] asc;
    logic [7:0] ascq;
  } sense_t;

  localparam sense_t SENSE_GOOD     = '{key: 4'h0, asc: 8'h00, ascq: 8'h00};
  localparam sense_t SENSE_NO_MEDIA = '{key: 4'h2, asc: 8'h3A, ascq: 8'h00};
  localparam sense_t SENSE_CHANGED  = '{key: 4'h6, asc: 8'h28, ascq: 8'h00};

endpackage

// File: rtl/detect_filter.sv
module detect_filter #(
  parameter int DEBOUNCE_CYCLES = 250000,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_raw,
  input  logic active_high,
  input  logic reload,
  output logic level_q
);
  localparam int CW = (DEBOUNCE_CYCLES > 2) ? $clog2(DEBOUNCE_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DEBOUNCE_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   inserted;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
  end

  assign inserted = active_high ? sync_q[SYNC_STAGES-1] : ~sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      level_q <= 1'b1;
      cnt_q   <= '0;
    end else if (inserted != level_q) begin
      if (cnt_q == CNT_LAST) begin
        level_q <= inserted;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  // R8: accepted level moves only after the full hold window
  a_r8_hold_window: assert property (@(posedge clk) disable iff (rst)
    (level_q != $past(level_q)) && !$past(reload) && !$past(rst) |-> $past(cnt_q) == CNT_LAST);

endmodule

// File: rtl/presence_state.sv
module presence_state (
  input  logic clk,
  input  logic rst,
  input  logic detect_en,
  input  logic filt_level,
  input  logic query,
  output logic present_q,
  output logic pending_q
);
  logic present_n;

  assign present_n = ~detect_en | filt_level;

  always_ff @(posedge clk) begin
    if (rst) begin
      present_q <= 1'b1;
      pending_q <= 1'b0;
    end else begin
      present_q <= present_n;
      if (!detect_en)
        pending_q <= 1'b0;
      else if (!present_n)
        pending_q <= 1'b0;
      else if (!present_q)
        pending_q <= 1'b1;
      else if (query && pending_q)
        pending_q <= 1'b0;
    end
  end

  // R7: an absent medium never carries a pending change
  a_r7_absent_clears: assert property (@(posedge clk) disable iff (rst)
    !present_q |-> !pending_q);

  // R2: disabled detection forces presence
  a_r2_forced_present: assert property (@(posedge clk) disable iff (rst)
    !detect_en |=> present_q);

endmodule

// File: rtl/sense_responder.sv
module sense_responder
  import media_sense_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       query,
  input  logic       present,
  input  logic       pending,
  output logic       rsp_valid,
  output logic [3:0] rsp_key,
  output logic [7:0] rsp_asc,
  output logic [7:0] rsp_ascq
);
  sense_t pick;

  always_comb begin
    if (!present)     pick = SENSE_NO_MEDIA;
    else if (pending) pick = SENSE_CHANGED;
    else              pick = SENSE_GOOD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_key   <= '0;
      rsp_asc   <= '0;
      rsp_ascq  <= '0;
    end else begin
      rsp_valid <= query;
      if (query) begin
        rsp_key  <= pick.key;
        rsp_asc  <= pick.asc;
        rsp_ascq <= pick.ascq;
      end
    end
  end

endmodule

// File: rtl/media_sense_tracker.sv
module media_sense_tracker #(
  parameter int DEBOUNCE_CYCLES = 250000,
  parameter int SYNC_STAGES     = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       det_raw,
  input  logic       cfg_detect_en,
  input  logic       cfg_active_high,
  input  logic       cfg_bus_search,
  input  logic       query,
  output logic       media_present,
  output logic       rsp_valid,
  output logic [3:0] rsp_key,
  output logic [7:0] rsp_asc,
  output logic [7:0] rsp_ascq,
  output logic       rem_unit_addr,
  output logic       scan_at_start
);
  logic filt_level;
  logic pending;

  detect_filter #(
    .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES),
    .SYNC_STAGES    (SYNC_STAGES)
  ) u_filter (
    .clk        (clk),
    .rst        (rst),
    .pin_raw    (det_raw),
    .active_high(cfg_active_high),
    .reload     (~cfg_detect_en),
    .level_q    (filt_level)
  );

  presence_state u_state (
    .clk       (clk),
    .rst       (rst),
    .detect_en (cfg_detect_en),
    .filt_level(filt_level),
    .query     (query),
    .present_q (media_present),
    .pending_q (pending)
  );

  sense_responder u_resp (
    .clk      (clk),
    .rst      (rst),
    .query    (query),
    .present  (media_present),
    .pending  (pending),
    .rsp_valid(rsp_valid),
    .rsp_key  (rsp_key),
    .rsp_asc  (rsp_asc),
    .rsp_ascq (rsp_ascq)
  );

  assign rem_unit_addr = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) scan_at_start <= 1'b0;
    else     scan_at_start <= cfg_bus_search;
  end

  // R10: one strobe per query, next cycle
  a_r10_answer: assert property (@(posedge clk) disable iff (rst)
    query |=> rsp_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !query |=> !rsp_valid);

  // R4: absent medium answers with the no-medium code
  a_r4_no_media: assert property (@(posedge clk) disable iff (rst)
    query && !media_present |=> rsp_asc == 8'h3A && rsp_key == 4'h2);

  // R6: a change report leaves nothing pending
  a_r6_once: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_asc == 8'h28 |-> !pending);

endmodule

// File: tb/media_sense_tracker_bench.sv
module media_sense_tracker_bench;
  localparam int DEB = 16;
  localparam int SETTLE = DEB + 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic det_raw = 1'b1;
  logic cfg_detect_en = 1'b1;
  logic cfg_active_high = 1'b1;
  logic cfg_bus_search = 1'b0;
  logic query = 1'b0;
  logic media_present, rsp_valid, rem_unit_addr, scan_at_start;
  logic [3:0] rsp_key;
  logic [7:0] rsp_asc, rsp_ascq;

  int total = 0;
  int bad = 0;
  logic [19:0] expq[$];
  string       tagq[$];

  localparam logic [19:0] GOOD = {4'h0, 8'h00, 8'h00};
  localparam logic [19:0] NOMED = {4'h2, 8'h3A, 8'h00};
  localparam logic [19:0] CHG = {4'h6, 8'h28, 8'h00};

  always #2 clk = ~clk;

  media_sense_tracker #(.DEBOUNCE_CYCLES(DEB)) u_media_sense_tracker (
    .clk(clk), .rst(rst), .det_raw(det_raw), .cfg_detect_en(cfg_detect_en),
    .cfg_active_high(cfg_active_high), .cfg_bus_search(cfg_bus_search),
    .query(query), .media_present(media_present), .rsp_valid(rsp_valid),
    .rsp_key(rsp_key), .rsp_asc(rsp_asc), .rsp_ascq(rsp_ascq),
    .rem_unit_addr(rem_unit_addr), .scan_at_start(scan_at_start));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ask(input logic [19:0] e, input string tag);
    expq.push_back(e);
    tagq.push_back(tag);
    query = 1'b1;
    cyc(1);
    query = 1'b0;
    cyc(1);
  endtask

  task automatic ask2(input logic [19:0] e1, input logic [19:0] e2, input string tag);
    expq.push_back(e1); tagq.push_back(tag);
    expq.push_back(e2); tagq.push_back(tag);
    query = 1'b1;
    cyc(2);
    query = 1'b0;
    cyc(1);
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (expq.size() == 0) begin
        check("R10 unexpected strobe", 32'(rsp_valid), 32'd0);
      end else begin
        automatic logic [19:0] e = expq.pop_front();
        automatic string t = tagq.pop_front();
        check(t, 32'({rsp_key, rsp_asc, rsp_ascq}), 32'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(5);
    check("R1 present in reset", 32'(media_present), 32'd1);
    check("R1 valid in reset", 32'(rsp_valid), 32'd0);
    rst = 1'b0;
    cyc(1);
    check("R1 present after reset", 32'(media_present), 32'd1);
    check("R1 valid after reset", 32'(rsp_valid), 32'd0);
    cyc(SETTLE);
    ask(GOOD, "R9 startup media no change");

    // R8 glitch shorter than window
    det_raw = 1'b0; cyc(DEB / 2); det_raw = 1'b1;
    cyc(SETTLE);
    check("R8 glitch ignored", 32'(media_present), 32'd1);
    ask(GOOD, "R8 glitch gives no report");

    // R4 removal
    det_raw = 1'b0; cyc(SETTLE);
    check("R4 absent flag", 32'(media_present), 32'd0);
    ask(NOMED, "R4 no media");
    ask(NOMED, "R4 no media repeat");

    // R5/R6 reinsertion, back-to-back queries
    det_raw = 1'b1; cyc(SETTLE);
    check("R5 present again", 32'(media_present), 32'd1);
    ask2(CHG, GOOD, "R5 R6 change then good");
    ask(GOOD, "R6 good afterwards");

    // R7 removal while change pending
    det_raw = 1'b0; cyc(SETTLE);
    det_raw = 1'b1; cyc(SETTLE);
    det_raw = 1'b0; cyc(SETTLE);
    ask(NOMED, "R7 pending cancelled");
    det_raw = 1'b1; cyc(SETTLE);
    ask(CHG, "R7 new insertion reported");
    ask(GOOD, "R6 cleared after report");

    // R3 active-low polarity: pin high now means absent
    cfg_active_high = 1'b0; cyc(SETTLE);
    check("R3 active low absent", 32'(media_present), 32'd0);
    ask(NOMED, "R3 active low no media");
    det_raw = 1'b0; cyc(SETTLE);
    check("R3 active low present", 32'(media_present), 32'd1);
    ask(CHG, "R3 active low change");

    // R2 detection disabled while pin says absent
    det_raw = 1'b1; cyc(SETTLE);
    check("R2 precondition absent", 32'(media_present), 32'd0);
    cfg_detect_en = 1'b0; cyc(2);
    check("R2 forced present", 32'(media_present), 32'd1);
    ask(GOOD, "R2 disabled good status");
    det_raw = 1'b0; cyc(3); det_raw = 1'b1; cyc(SETTLE);
    check("R2 pin ignored", 32'(media_present), 32'd1);
    ask(GOOD, "R2 disabled still good");

    // R11 fixed outputs
    check("R11 unit address", 32'(rem_unit_addr), 32'd0);
    cfg_bus_search = 1'b1; cyc(1);
    check("R11 scan follows 1", 32'(scan_at_start), 32'd1);
    cfg_bus_search = 1'b0; cyc(1);
    check("R11 scan follows 0", 32'(scan_at_start), 32'd0);

    cyc(4);
    check("R10 all queries answered", 32'(expq.size()), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule